// File: doc/BRIEF.md
# Power-of-Two Clock Divider with Gated Output

The block takes a reference clock and produces a derived clock whose frequency is the reference divided by a power of two between 1 and 64. Software controls the block through a byte-wide register port with an address, write data, a write strobe and combinational read data. One register holds a 3-bit divide code. A second register holds an output-enable bit and a read-only bit that shows whether the gated output is actually running.

The derived clock is gated without glitches. A new enable request passes through a two-stage resynchroniser before it can open the gate. The gate only opens or closes while the divided waveform is low, so every pulse on the output has full width. A disable request skips the resynchroniser, which keeps the stop latency short even at divide-by-1.

While the output runs, a new divide code takes effect only at the next divided-period boundary. While the output is stopped, a new code is loaded on the next reference edge. The intended software sequence is: disable, wait for the running bit to clear, write the code, then enable again.

Top module: `pow2_clk_divider`

## Requirements
- R1: After reset both registers read zero, the running bit is 0, the output is held low and the divider is set to divide-by-1.
- R2: The divide code is bits [2:0] of the register at address 0x43. Reading that register returns the stored code with bits [7:3] as zero, whatever was written to them.
- R3: In the register at address 0x46, bit 7 is the output enable and bit 0 is the read-only running flag. Writing bit 0 has no effect, and the other bits read zero. Writes to any other address change nothing, and reads from any other address return zero.
- R4: Codes 0 and 1 both select divide-by-1. A code n from 2 to 7 selects divide-by-2^(n-1), so code 7 gives divide-by-64.
- R5: With divide ratio N of 2 or more, the running output is high for N/2 reference cycles and low for N/2 reference cycles. With N = 1, the running output follows the reference clock.
- R6: After the write edge that sets the enable, the running flag is 1 and the output toggles within 2 + 3N reference cycles.
- R7: After the write edge that clears the enable, the running flag is 0 and the output is low within 3N reference cycles, and the output then stays low.
- R8: The gate opens and closes only while the divided waveform is low, so every high pulse on the output, including the first and the last, lasts exactly N/2 reference cycles for N of 2 or more.
- R9: A divide code written while the output runs takes effect only at the next period boundary. Every later pulse uses the new ratio, with no shortened pulse.
- R10: The running flag is 1 exactly while the gate is open: it reads 1 while pulses are emitted and 0 once the output has stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all registers use it |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_we | input | 1 | Write strobe, sampled on the rising reference edge |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| div_clk_out | output | 1 | Gated divided clock |

## Verification
Two functions can act on the same reference edge. A divide-code write can land on the period boundary where the counter reloads. A disable can arrive on the edge where a new high phase begins. The first case is provoked by rewriting the code while the output runs at an unknown phase. The bench then requires every high and low phase from the next clean rising edge onward to match the new ratio. The second case is provoked by clearing the enable at each ratio. The bench requires any pulse that starts after the disable to run to its full width before the output settles low.

// File: rtl/pow2div_pkg.sv
package pow2div_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = (1 << CODE_W) - 2;
  localparam int DIV_W  = CNT_W + 1;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [DIV_W-1:0]  div_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // Codes below 2 share ratio 1; above that the ratio doubles per step.
  function automatic div_t code_to_div(input code_t code);
    div_t d;
    d = '0;
    if (code < code_t'(2)) d[0] = 1'b1;
    else d[code - code_t'(1)] = 1'b1;
    return d;
  endfunction
endpackage

// File: rtl/pow2div_regs.sv
module pow2div_regs
  import pow2div_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] DIV_ADDR = 'h43,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 'h46,
  parameter int EN_BIT   = 7,
  parameter int STAT_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              run_i,
  output code_t             code_o,
  output logic              en_o,
  output logic [DATA_W-1:0] rdata_o
);
  code_t code_q, code_d;
  logic  en_q, en_d;
  logic  code_we, en_we;
  logic  unused_wbits;

  assign unused_wbits = ^wdata_i[EN_BIT-1:CODE_W];

  assign code_we = wr_i && (addr_i == DIV_ADDR);
  assign en_we   = wr_i && (addr_i == EN_ADDR);

  always_comb begin
    code_d = code_q;
    en_d   = en_q;
    if (code_we) code_d = wdata_i[CODE_W-1:0];
    if (en_we)   en_d   = wdata_i[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (code_we) code_q <= code_d;
      if (en_we)   en_q   <= en_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == DIV_ADDR) begin
      rdata_o[CODE_W-1:0] = code_q;
    end else if (addr_i == EN_ADDR) begin
      rdata_o[EN_BIT]   = en_q;
      rdata_o[STAT_BIT] = run_i;
    end
  end

  assign code_o = code_q;
  assign en_o   = en_q;

  // R2: a code write is visible on the next cycle
  assert_code_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    code_we |=> (code_q == $past(wdata_i[CODE_W-1:0])));

  // R3: writes to unmapped addresses leave both fields alone
  assert_other_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (addr_i != DIV_ADDR) && (addr_i != EN_ADDR)) |=> ($stable(code_q) && $stable(en_q)));
endmodule

// File: rtl/pow2div_counter.sv
module pow2div_counter
  import pow2div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t code_i,
  input  logic  running_i,
  output div_t  div_o,
  output logic  phase_q_o,
  output logic  phase_d_o
);
  div_t div_q, div_d, want;
  cnt_t cnt_q, cnt_d;
  logic phase_q, phase_d;
  logic at_last, reload;

  always_comb begin
    want    = code_to_div(code_i);
    at_last = ({1'b0, cnt_q} == (div_q - div_t'(1)));
    // Running: switch only at the period end. Stopped: switch at once.
    reload  = at_last || (!running_i && (want != div_q));
    if (reload) begin
      cnt_d = '0;
      div_d = want;
    end else begin
      cnt_d = cnt_q + cnt_t'(1);
      div_d = div_q;
    end
    phase_d = ({1'b0, cnt_d} < (div_d >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      div_q   <= div_t'(1);
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      div_q   <= div_d;
      phase_q <= phase_d;
    end
  end

  assign div_o     = div_q;
  assign phase_q_o = phase_q;
  assign phase_d_o = phase_d;

  // R4: the active ratio is always a single power of two
  assert_ratio_pow2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(div_q) == 1);

  // R5: the count never reaches the ratio
  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_q} < div_q);

  // R9: while running, the ratio changes only after the last count of a period
  assert_switch_at_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running_i) && !$stable(div_q)) |-> ($past(at_last) && (cnt_q == '0)));
endmodule

// File: rtl/pow2div_gate.sv
module pow2div_gate
  import pow2div_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic phase_q_i,
  input  logic phase_d_i,
  input  div_t div_i,
  output logic run_o,
  output logic clk_o
);
  logic sync1_q, sync2_q;
  logic run_q, run_d;
  logic fast_nq;
  logic div1;

  assign div1 = div_i[0];

  // Two-stage resynchroniser on the enable request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= en_i;
      sync2_q <= sync1_q;
    end
  end

  // Open while the waveform is low now; close while it will be low next
  always_comb begin
    run_d = run_q;
    if (!run_q && en_i && sync2_q && !phase_q_i) run_d = 1'b1;
    else if (run_q && !en_i && !phase_d_i)       run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  // Divide-by-1 path: the gate term changes while the reference is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fast_nq <= 1'b0;
    else        fast_nq <= run_q & div1;
  end

  assign clk_o = (fast_nq & clk) | (phase_q_i & run_q);
  assign run_o = run_q;

  // Latency watch counters for the checks below
  logic [DIV_W+1:0] stop_cnt_q, start_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_cnt_q  <= '0;
      start_cnt_q <= '0;
    end else begin
      if (!en_i && run_q) stop_cnt_q <= (&stop_cnt_q) ? stop_cnt_q : stop_cnt_q + 1'b1;
      else                stop_cnt_q <= '0;
      if (en_i && !run_q) start_cnt_q <= (&start_cnt_q) ? start_cnt_q : start_cnt_q + 1'b1;
      else                start_cnt_q <= '0;
    end
  end

  // R8: the gate opens only while the divided waveform is low
  assert_open_in_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> !$past(phase_q_i));

  // R8: the gate closes only into a low phase
  assert_close_in_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> !phase_q_i);

  // R7: the gate closes within one divided period of a disable
  assert_stop_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cnt_q <= {2'b00, div_i});

  // R6: the gate opens within the resync delay plus one divided period
  assert_start_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_cnt_q <= ({2'b00, div_i} + 4));

  // R10: the gate never opens without a pending enable
  assert_open_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> ($past(en_i) && $past(sync2_q)));
endmodule

// File: rtl/pow2_clk_divider.sv
module pow2_clk_divider
  import pow2div_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] DIV_ADDR = 'h43,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 'h46,
  parameter int EN_BIT   = 7,
  parameter int STAT_BIT = 0
) (
  input  logic              ref_clk,
  input  logic              arst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              div_clk_out
);
  logic  rst_meta_q, rst_sync_q;
  code_t code;
  logic  en;
  logic  running;
  div_t  div_act;
  logic  phase_q, phase_d;

  // Asynchronous assert, synchronous release
  always_ff @(posedge ref_clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pow2div_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_ADDR(DIV_ADDR), .EN_ADDR(EN_ADDR),
    .EN_BIT(EN_BIT), .STAT_BIT(STAT_BIT)
  ) u_regs (
    .clk(ref_clk), .rst_n(rst_sync_q), .wr_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .run_i(running), .code_o(code), .en_o(en), .rdata_o(bus_rdata)
  );

  pow2div_counter u_cnt (
    .clk(ref_clk), .rst_n(rst_sync_q), .code_i(code), .running_i(running),
    .div_o(div_act), .phase_q_o(phase_q), .phase_d_o(phase_d)
  );

  pow2div_gate u_gate (
    .clk(ref_clk), .rst_n(rst_sync_q), .en_i(en), .phase_q_i(phase_q),
    .phase_d_i(phase_d), .div_i(div_act), .run_o(running), .clk_o(div_clk_out)
  );
endmodule

// File: tb/sim_pow2_clk_divider.sv
module sim_pow2_clk_divider;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DIV = 8'h43;
  localparam logic [7:0] A_EN  = 8'h46;
  // stimulus: divide code = index, expected ratio = entry
  localparam int EXP_DIV [8] = '{1, 1, 2, 4, 8, 16, 32, 64};

  logic clk, arst_n, we, dclk;
  logic [7:0] addr, wdata, rdata;
  int checks, fails;
  bit done;
  int hl [4];
  int ll [4];

  pow2_clk_divider u0 (
    .ref_clk(clk), .arst_n(arst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .div_clk_out(dclk)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0; addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // skip to a low sample, then record nruns high lengths and the lows between
  task automatic measure(input int nruns, output bit to);
    int guard, hlen, llen, idx;
    guard = 0; hlen = 0; llen = 0; idx = 0;
    while (dclk !== 1'b0 && guard < 300) begin tick(); guard++; end
    while (idx < nruns && guard < 1200) begin
      if (dclk === 1'b1) begin
        if (hlen == 0 && idx > 0) ll[idx-1] = llen;
        hlen++;
      end else begin
        if (hlen > 0) begin hl[idx] = hlen; idx++; hlen = 0; llen = 0; end
        llen++;
      end
      if (idx < nruns) begin tick(); guard++; end
    end
    to = (idx < nruns);
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int highs;
    bit to;
    checks = 0; fails = 0; done = 0;
    arst_n = 1'b0; we = 1'b0; addr = 8'h00; wdata = 8'h00;
    repeat (4) tick();
    check(dclk === 1'b0, "R1 output low in reset", int'(dclk), 0);
    arst_n = 1'b1;
    repeat (4) tick();

    // R1: reset state
    rd(A_DIV, r); check(r == 8'h00, "R1 divide register", int'(r), 0);
    rd(A_EN, r);  check(r == 8'h00, "R1 enable register", int'(r), 0);
    highs = 0;
    for (int k = 0; k < 8; k++) begin if (dclk !== 1'b0) highs++; tick(); end
    check(highs == 0, "R1 output idle", highs, 0);

    // R3: running flag is read-only
    wr(A_EN, 8'h01);
    rd(A_EN, r); check(r == 8'h00, "R3 write to running flag ignored", int'(r), 0);
    highs = 0;
    for (int k = 0; k < 8; k++) begin if (dclk !== 1'b0) highs++; tick(); end
    check(highs == 0, "R3 output stays off", highs, 0);

    // R2: upper bits of the divide register read zero
    wr(A_DIV, 8'hFE);
    rd(A_DIV, r); check(r == 8'h06, "R2 code field only", int'(r), 6);
    wr(A_DIV, 8'h00);

    // R3: unmapped write and read
    wr(8'h44, 8'hFF);
    rd(A_DIV, r); check(r == 8'h00, "R3 unmapped write keeps code", int'(r), 0);
    rd(A_EN, r);  check(r == 8'h00, "R3 unmapped write keeps enable", int'(r), 0);
    rd(8'h44, r); check(r == 8'h00, "R3 unmapped read zero", int'(r), 0);

    // R9: code change while running at /4 to /8
    wr(A_DIV, 8'h03);
    wr(A_EN, 8'h80);
    for (int k = 0; k < 20; k++) tick();
    rd(A_EN, r); check(r == 8'h81, "R10 running at /4", int'(r), 8'h81);
    wr(A_DIV, 8'h04);
    measure(3, to);
    check(!to && hl[0] == 4 && hl[1] == 4 && hl[2] == 4, "R9 new high width", hl[0], 4);
    check(ll[0] == 4 && ll[1] == 4, "R9 new low width", ll[0], 4);
    wr(A_EN, 8'h00);
    for (int k = 0; k < 30; k++) tick();
    rd(A_EN, r); check(r == 8'h00, "R10 stopped after /8", int'(r), 0);

    // table walk over every code
    for (int i = 0; i < 8; i++) begin
      int n, bound, k_stat, k_out, k_stop, runt, hlen;
      bit trk;
      logic prev;
      n = EXP_DIV[i];
      wr(A_DIV, 8'(i));
      rd(A_DIV, r);
      check(r == 8'(i), $sformatf("R2 readback code %0d", i), int'(r), i);

      // R6 start latency
      wr(A_EN, 8'h80);
      bound = 2 + 3 * n; k_stat = -1; k_out = -1;
      for (int k = 0; k <= bound; k++) begin
        rd(A_EN, r);
        if (r[0] && k_stat < 0) k_stat = k;
        if (dclk === 1'b1 && k_out < 0) k_out = k;
        if (k < bound) tick();
      end
      check(k_stat >= 0, $sformatf("R6 running flag code %0d", i), k_stat, bound);
      check(k_out >= 0, $sformatf("R6 first pulse code %0d", i), k_out, bound);

      // R4 and R5 waveform
      if (n == 1) begin
        highs = 0;
        for (int k = 0; k < 8; k++) begin tick(); if (dclk === 1'b1) highs++; end
        check(highs == 8, $sformatf("R4 R5 follows reference code %0d", i), highs, 8);
      end else begin
        measure(3, to);
        check(!to && hl[0] == n/2 && hl[1] == n/2 && hl[2] == n/2,
              $sformatf("R5 R8 high width code %0d", i), hl[1], n/2);
        check(ll[0] == n/2 && ll[1] == n/2, $sformatf("R4 low width code %0d", i), ll[0], n/2);
      end
      rd(A_EN, r); check(r == 8'h81, $sformatf("R10 flag while running code %0d", i), int'(r), 8'h81);

      // R7 stop latency, R8 no runt on the way out
      wr(A_EN, 8'h00);
      bound = 3 * n; k_stop = -1; runt = 0; hlen = 0; trk = 0; prev = dclk;
      for (int k = 0; k <= bound; k++) begin
        rd(A_EN, r);
        if (r[0] == 1'b0 && dclk === 1'b0 && k_stop < 0) k_stop = k;
        if (dclk === 1'b1 && prev === 1'b0) begin trk = 1; hlen = 1; end
        else if (dclk === 1'b1 && trk) hlen++;
        else if (dclk === 1'b0 && trk) begin if (hlen != n/2) runt++; trk = 0; end
        prev = dclk;
        if (k < bound) tick();
      end
      check(k_stop >= 0, $sformatf("R7 stop code %0d", i), k_stop, bound);
      if (n >= 2) check(runt == 0, $sformatf("R8 closing pulse code %0d", i), runt, 0);
      highs = 0;
      for (int k = 0; k < 2 * n + 4; k++) begin tick(); if (dclk !== 1'b0) highs++; end
      check(highs == 0, $sformatf("R7 held low code %0d", i), highs, 0);
      rd(A_EN, r); check(r == 8'h00, $sformatf("R10 flag clear code %0d", i), int'(r), 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule